// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a pipelined SRAM whose data moves on both halves of the clock. Every access is a fixed two-word burst. A command is taken on the rising clock edge, and at most one command is taken per cycle. Write words arrive one per clock edge during the cycle after the command. Read words leave one per clock edge, starting a cycle and a half after the command. The shared data bus appears as separate input and output vectors plus an output-enable that a pad ring or a bench turns into a tri-state driver. The falling clock edge stands in for the rising edge of the inverted clock, and the read data is launched from the same pair of edges.

A write is not placed in the array at once. It lands in a stage register, moves into a one-entry pending register, and reaches the array only when the next write pushes it out. Any read compares its burst address against the stage and pending entries and merges their enabled byte lanes over the array contents. A read can therefore follow a write with no idle cycle and still return the newest data. Each lane is nine bits wide, with its own active-low write enable.

Top module: `ddr_b2_sram`

## Requirements
- R1: A command is taken on a rising clock edge only when `load_n` is 0. `rd_wr_n` = 1 then selects a read and 0 a write. A cycle with `load_n` = 1 changes no stored data and starts no output.
- R2: A burst covers word addresses A and A^1, where A is the `addr` value with the command. Bit 0 may be 1. The first word of a burst goes to or comes from A, and the second word from A^1.
- R3: For a write taken on edge n, the first word (with its enables) is sampled from `wdata`/`lane_we_n` on rising edge n+1, and the second word on the falling edge that follows.
- R4: For a read taken on rising edge n, `rdata` carries the first word while the clock is low after the falling edge at n+1.5. It carries the second word while the clock is high after rising edge n+2.
- R5: `rdata_oe` is 1 from the falling edge at n+1.5 up to the falling edge at n+2.5 for each read taken at n. It is 0 during any such span that follows a cycle with no read.
- R6: `lane_we_n[i]` = 0 writes bits [9i+8:9i] of the word. A value of 1 leaves that lane of the stored word unchanged.
- R7: A read issued in the cycle right after a write to the same burst returns that write's data.
- R8: When a partial write is still posted, a read merges only its enabled lanes over the older contents of the burst.
- R9: A chain of writes to different bursts keeps every burst coherent. Each posted write is moved into the array when the next write replaces it.
- R10: While `rst_n` = 0 on a clock edge, any read in flight is dropped, and `rdata_oe` is 0 once reset has been seen on both edges.
- R11: Reads on consecutive cycles give a gapless word stream, with `rdata_oe` held at 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock. The falling edge acts as the complementary clock's rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low command strobe |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 9 | Word address (bits [8:1] select the burst, bit 0 the start word) |
| lane_we_n | input | 2 | Active-low lane write enables, one per 9-bit lane, sampled with each write word |
| wdata | input | 18 | Write word, sampled on both clock edges |
| rdata | output | 18 | Read word, launched on both clock edges |
| rdata_oe | output | 1 | Output-enable for the shared data bus |

## Verification
A stale or lost posted-write entry shows up at the ports as a wrong lane value. It appears on the first read of that burst, a cycle and a half after the read command, so reads are issued both right after writes and after further writes have pushed entries into the array. A wrong read pipeline state shows as `rdata_oe` or a word that is half a cycle early or late. The enable and the data are therefore compared in the middle of every clock phase against a model that applies writes word by word. A lane the model has never written is masked out of the data compare.

// File: rtl/ddr_b2_pkg.sv
// Shared types for the burst-of-two DDR SRAM model.
// Assumes: one command per rising clock edge, decoded from strobe and direction.
package ddr_b2_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2
    } bus_cmd_e;

    // Turn the strobe and direction pins into a command code.
    function automatic bus_cmd_e decode_cmd(input logic load_n, input logic rd_wr_n);
        if (load_n) begin
            return CMD_NOP;
        end
        return rd_wr_n ? CMD_RD : CMD_WR;
    endfunction

endpackage

// File: rtl/ddr_b2_array.sv
// Storage array: one memory per (burst slot, lane), written per lane.
// Assumes: a write and a read of the same location in one cycle return the old
// value (newer data is supplied by the bypass path, not by the array).
module ddr_b2_array #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 256,
    localparam int DW    = LANES * LANE_W,
    localparam int BAW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      wr_v,
    input  logic [BAW-1:0]            wr_baddr,
    input  logic [1:0][DW-1:0]        wr_data,
    input  logic [1:0][LANES-1:0]     wr_en,
    input  logic [BAW-1:0]            rd_baddr,
    output logic [1:0][DW-1:0]        rd_data
);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            // Commit one lane of one burst word when its enable is set.
            always_ff @(posedge clk) begin
                if (wr_v && wr_en[s][l]) begin
                    mem[wr_baddr] <= wr_data[s][l*LANE_W +: LANE_W];
                end
            end

            assign rd_data[s][l*LANE_W +: LANE_W] = mem[rd_baddr];
        end
    end

endmodule

// File: rtl/ddr_b2_wr_post.sv
// Write posting: captures the two write words on both clock edges into a stage,
// then moves the stage into a one-entry pending register on the next rising
// edge; the entry it replaces is presented to the array as a commit.
// Assumes: data words arrive on rising edge n+1 and falling edge n+1.5 for a
// write taken on rising edge n; stage and pending slots are kept in array order.
module ddr_b2_wr_post #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 256,
    localparam int DW    = LANES * LANE_W,
    localparam int BAW   = $clog2(DEPTH),
    localparam int AW    = BAW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_cmd,
    input  logic [AW-1:0]             cmd_addr,
    input  logic [DW-1:0]             wdata,
    input  logic [LANES-1:0]          lane_we_n,
    output logic                      stg_v,
    output logic [BAW-1:0]            stg_baddr,
    output logic [1:0][DW-1:0]        stg_data,
    output logic [1:0][LANES-1:0]     stg_en,
    output logic                      pend_v,
    output logic [BAW-1:0]            pend_baddr,
    output logic [1:0][DW-1:0]        pend_data,
    output logic [1:0][LANES-1:0]     pend_en,
    output logic                      commit_v
);

    logic             stg_lsb;
    logic [DW-1:0]    pos_word, neg_word;
    logic [LANES-1:0] pos_en, neg_en;

    // Rising edge: first data word and the command that owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= 1'b0;
        end else begin
            stg_v <= wr_cmd;
        end
        stg_baddr <= cmd_addr[AW-1:1];
        stg_lsb   <= cmd_addr[0];
        pos_word  <= wdata;
        pos_en    <= ~lane_we_n;
    end

    // Falling edge: second data word.
    always_ff @(negedge clk) begin
        neg_word <= wdata;
        neg_en   <= ~lane_we_n;
    end

    // Place the words in array order: first word at the start slot.
    always_comb begin
        stg_data[stg_lsb]  = pos_word;
        stg_en[stg_lsb]    = pos_en;
        stg_data[~stg_lsb] = neg_word;
        stg_en[~stg_lsb]   = neg_en;
    end

    // Move a complete stage into the pending entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
        end else if (stg_v) begin
            pend_v     <= 1'b1;
            pend_baddr <= stg_baddr;
            pend_data  <= stg_data;
            pend_en    <= stg_en;
        end
    end

    assign commit_v = stg_v && pend_v;

    // R9
    pend_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_v |=> pend_v);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_v |=> ($stable(pend_baddr) && $stable(pend_data) && $stable(pend_en)));

endmodule

// File: rtl/ddr_b2_rd_path.sv
// Read path: merges stage, pending and array data lane by lane, holds the
// burst for one cycle, then launches word one on the falling edge and word two
// on the following rising edge, with a falling-edge output-enable.
// Assumes: the stage holds the newest write and outranks the pending entry;
// both are compared at burst granularity.
module ddr_b2_rd_path #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 256,
    localparam int DW    = LANES * LANE_W,
    localparam int BAW   = $clog2(DEPTH),
    localparam int AW    = BAW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_cmd,
    input  logic [AW-1:0]             rd_addr,
    input  logic [1:0][DW-1:0]        arr_data,
    input  logic                      stg_v,
    input  logic [BAW-1:0]            stg_baddr,
    input  logic [1:0][DW-1:0]        stg_data,
    input  logic [1:0][LANES-1:0]     stg_en,
    input  logic                      pend_v,
    input  logic [BAW-1:0]            pend_baddr,
    input  logic [1:0][DW-1:0]        pend_data,
    input  logic [1:0][LANES-1:0]     pend_en,
    output logic [BAW-1:0]            arr_baddr,
    output logic [DW-1:0]             rdata,
    output logic                      rdata_oe
);

    logic              stg_hit, pend_hit;
    logic [1:0][DW-1:0] merged;
    logic              rb_v;
    logic [DW-1:0]     rb_first, rb_second;
    logic [DW-1:0]     pos_q, neg_q;
    logic              oe_q;

    assign arr_baddr = rd_addr[AW-1:1];
    assign stg_hit   = stg_v  && (stg_baddr  == rd_addr[AW-1:1]);
    assign pend_hit  = pend_v && (pend_baddr == rd_addr[AW-1:1]);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign merged[s][l*LANE_W +: LANE_W] =
                (stg_hit  && stg_en[s][l])  ? stg_data[s][l*LANE_W +: LANE_W]  :
                (pend_hit && pend_en[s][l]) ? pend_data[s][l*LANE_W +: LANE_W] :
                                              arr_data[s][l*LANE_W +: LANE_W];
        end
    end

    // Hold the merged burst in output order for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_v <= 1'b0;
        end else begin
            rb_v <= rd_cmd;
        end
        rb_first  <= merged[rd_addr[0]];
        rb_second <= merged[~rd_addr[0]];
    end

    // Falling edge: launch the first word and open the output.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= rb_v;
        end
        neg_q <= rb_first;
    end

    // Rising edge: launch the second word of the burst held last cycle.
    always_ff @(posedge clk) begin
        pos_q <= rb_second;
    end

    assign rdata    = clk ? pos_q : neg_q;
    assign rdata_oe = oe_q;

    // R7
    stg_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !rd_addr[0] && stg_hit && (&stg_en[0]))
        |=> (rb_first == $past(stg_data[0])));

endmodule

// File: rtl/ddr_b2_sram.sv
// Top of the burst-of-two DDR SRAM model: command register, write posting,
// storage array and read path.
// Assumes: at most one command per rising edge; the caller keeps the shared
// bus free of read/write overlap, which this model presents as split vectors.
module ddr_b2_sram
    import ddr_b2_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 256,
    localparam int DW    = LANES * LANE_W,
    localparam int BAW   = $clog2(DEPTH),
    localparam int AW    = BAW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              rd_wr_n,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rdata_oe
);

    bus_cmd_e             cmd_q;
    logic [AW-1:0]        cmd_addr;
    logic                 stg_v, pend_v, commit_v;
    logic [BAW-1:0]       stg_baddr, pend_baddr, arr_baddr;
    logic [1:0][DW-1:0]   stg_data, pend_data, arr_data;
    logic [1:0][LANES-1:0] stg_en, pend_en;

    // Bus-cycle state: the command taken on this rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
        end else begin
            cmd_q <= decode_cmd(load_n, rd_wr_n);
        end
        cmd_addr <= addr;
    end

    ddr_b2_wr_post #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (cmd_q == CMD_WR),
        .cmd_addr   (cmd_addr),
        .wdata      (wdata),
        .lane_we_n  (lane_we_n),
        .stg_v      (stg_v),
        .stg_baddr  (stg_baddr),
        .stg_data   (stg_data),
        .stg_en     (stg_en),
        .pend_v     (pend_v),
        .pend_baddr (pend_baddr),
        .pend_data  (pend_data),
        .pend_en    (pend_en),
        .commit_v   (commit_v)
    );

    ddr_b2_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
        .clk      (clk),
        .wr_v     (commit_v),
        .wr_baddr (pend_baddr),
        .wr_data  (pend_data),
        .wr_en    (pend_en),
        .rd_baddr (arr_baddr),
        .rd_data  (arr_data)
    );

    ddr_b2_rd_path #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (cmd_q == CMD_RD),
        .rd_addr    (cmd_addr),
        .arr_data   (arr_data),
        .stg_v      (stg_v),
        .stg_baddr  (stg_baddr),
        .stg_data   (stg_data),
        .stg_en     (stg_en),
        .pend_v     (pend_v),
        .pend_baddr (pend_baddr),
        .pend_data  (pend_data),
        .pend_en    (pend_en),
        .arr_baddr  (arr_baddr),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

    // R5
    rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && rd_wr_n) |-> ##2 rdata_oe);

    // R5
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || !rd_wr_n) |-> ##2 !rdata_oe);

    // R1
    nop_no_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || rd_wr_n) |-> ##2 !stg_v);

endmodule

// File: tb/ddr_b2_sram_tb.sv
// Bench: a behavioural model (word-addressed memory, applied word by word)
// predicts rdata_oe and rdata for every clock phase; both are compared mid-phase.
module ddr_b2_sram_tb;

    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DEPTH  = 256;
    localparam int DW     = LANES * LANE_W;
    localparam int AW     = $clog2(DEPTH) + 1;
    localparam int NW     = 2 * DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1;
    logic              rd_wr_n = 1'b1;
    logic [AW-1:0]     addr = '0;
    logic [LANES-1:0]  lane_we_n = '1;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              rdata_oe;

    always #2 clk = ~clk;

    ddr_b2_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr_n(rd_wr_n), .addr(addr),
        .lane_we_n(lane_we_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R4";
    bit    done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [DW-1:0]    mm [NW];
    logic [LANES-1:0] kn [NW];
    bit               r1, r2, w1, wpend;
    logic [AW-1:0]    a1, wa;
    logic [DW-1:0]    wd0;
    logic [LANES-1:0] wb0;
    bit               lo_oe, hi_oe;
    logic [DW-1:0]    lo_exp, hi_exp, e1_hold, lo_msk, hi_msk, m1_hold;

    initial begin
        for (int i = 0; i < NW; i++) kn[i] = '0;
    end

    function automatic logic [DW-1:0] lmask(input logic [LANES-1:0] k);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{k[i]}};
        return m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            r1 = 0; r2 = 0; w1 = 0; wpend = 0; lo_oe = 0; hi_oe = 0;
        end else begin
            hi_oe  = r2;  hi_exp = e1_hold; hi_msk = m1_hold;
            lo_oe  = r1;
            lo_exp = mm[a1];    lo_msk  = lmask(kn[a1]);
            e1_hold = mm[a1 ^ 1]; m1_hold = lmask(kn[a1 ^ 1]);
            wpend = w1;
            if (w1) begin wa = a1; wd0 = wdata; wb0 = lane_we_n; end
            r2 = r1;
            r1 = !load_n && rd_wr_n;
            w1 = !load_n && !rd_wr_n;
            a1 = addr;
        end
    end

    always @(negedge clk) begin
        if (rst_n && wpend) begin
            for (int i = 0; i < LANES; i++) begin
                if (!wb0[i]) begin
                    mm[wa][i*LANE_W +: LANE_W] = wd0[i*LANE_W +: LANE_W];
                    kn[wa][i] = 1'b1;
                end
                if (!lane_we_n[i]) begin
                    mm[wa ^ 1][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
                    kn[wa ^ 1][i] = 1'b1;
                end
            end
            wpend = 0;
        end
    end

    // High phase compare (second word of a read taken two edges back).
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(rdata_oe === hi_oe, "R5", "oe high phase", {17'd0, rdata_oe}, {17'd0, hi_oe});
            if (hi_oe)
                chk((rdata & hi_msk) === (hi_exp & hi_msk), cur_tag, "second word",
                    rdata & hi_msk, hi_exp & hi_msk);
        end
    end

    // Low phase compare (first word of the read taken one edge back).
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(rdata_oe === lo_oe, "R5", "oe low phase", {17'd0, rdata_oe}, {17'd0, lo_oe});
            if (lo_oe)
                chk((rdata & lo_msk) === (lo_exp & lo_msk), cur_tag, "first word",
                    rdata & lo_msk, lo_exp & lo_msk);
        end
    end

    // ---------------- stimulus ----------------
    logic [DW-1:0]    nd0 = '0, nd1 = '0;
    logic [LANES-1:0] nb0 = '1, nb1 = '1;

    // One command cycle; data given with rd_wr_n = 0 is driven in the next cycle.
    task automatic cyc(input bit ld, input bit rwv, input logic [AW-1:0] a,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [LANES-1:0] b0, input logic [LANES-1:0] b1);
        load_n = ld; rd_wr_n = rwv; addr = a; wdata = nd0; lane_we_n = nb0;
        @(posedge clk); #1;
        wdata = nd1; lane_we_n = nb1;
        if (!rwv) begin nd0 = d0; nd1 = d1; nb0 = b0; nb1 = b1; end
        else begin nd0 = '0; nd1 = '0; nb0 = '1; nb1 = '1; end
        @(negedge clk); #1;
    endtask

    task automatic nop();
        cyc(1, 1, '0, '0, '0, '1, '1);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        cyc(0, 1, a, '0, '0, '1, '1);
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [LANES-1:0] b0, input logic [LANES-1:0] b1);
        cyc(0, 0, a, d0, d1, b0, b1);
    endtask

    initial begin
        #1;
        // R10: reset state
        rst_n = 0;
        repeat (3) nop();
        chk(rdata_oe === 1'b0, "R10", "oe in reset", {17'd0, rdata_oe}, '0);
        rst_n = 1;
        rd(9'h004);
        rst_n = 0;                     // R10: drop an in-flight read
        nop(); nop();
        rst_n = 1;
        nop();
        chk(rdata_oe === 1'b0, "R10", "oe after mid-flight reset", {17'd0, rdata_oe}, '0);
        nop(); nop();

        // R3/R4: full write then read after idle cycles
        cur_tag = "R4";
        wr(9'h010, 18'h1A5A5, 18'h05A5A, 2'b00, 2'b00);
        nop(); nop();
        rd(9'h010); nop(); nop();
        cur_tag = "R3";
        rd(9'h011); nop(); nop();

        // R2: odd start address, word order wraps within the burst
        cur_tag = "R2";
        wr(9'h021, 18'h11111, 18'h22222, 2'b00, 2'b00);
        nop();
        rd(9'h020); rd(9'h021); nop(); nop();

        // R7: read directly after write to the same burst
        cur_tag = "R7";
        wr(9'h030, 18'h3C3C3, 18'h0F0F0, 2'b00, 2'b00);
        rd(9'h030); nop(); nop();
        wr(9'h031, 18'h2AAAA, 18'h15555, 2'b00, 2'b00);
        rd(9'h030); nop(); nop();

        // R6: lane enables on a committed word
        cur_tag = "R6";
        wr(9'h040, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
        wr(9'h040, 18'h00000, 18'h00000, 2'b10, 2'b01);
        wr(9'h042, 18'h00001, 18'h00002, 2'b00, 2'b00);
        wr(9'h044, 18'h00003, 18'h00004, 2'b00, 2'b00);
        nop();
        rd(9'h040); nop(); nop();

        // R8: partial write still posted, merged over older data
        cur_tag = "R8";
        wr(9'h050, 18'h12345, 18'h2ABCD, 2'b00, 2'b00);
        wr(9'h050, 18'h00000, 18'h3FFFF, 2'b01, 2'b10);
        rd(9'h050); nop();
        rd(9'h051); nop(); nop();

        // R9: chained writes commit earlier entries
        cur_tag = "R9";
        wr(9'h060, 18'h00606, 18'h00607, 2'b00, 2'b00);
        wr(9'h062, 18'h00626, 18'h00627, 2'b00, 2'b00);
        wr(9'h064, 18'h00646, 18'h00647, 2'b00, 2'b00);
        wr(9'h066, 18'h00666, 18'h00667, 2'b00, 2'b00);
        // R11: back-to-back reads stream without gaps
        cur_tag = "R11";
        rd(9'h060); rd(9'h062); rd(9'h064); rd(9'h066); nop(); nop();

        // R1: idle cycles with write direction and data on the bus change nothing
        cur_tag = "R1";
        cyc(1, 0, 9'h060, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
        nop();
        cyc(1, 1, 9'h062, '0, '0, '1, '1);
        rd(9'h060); nop(); nop();

        // Mixed traffic over a few bursts (newest-data coherency, R7)
        cur_tag = "R7";
        for (int i = 0; i < 200; i++) begin
            int op;
            op = $urandom % 3;
            if (op == 0)
                wr(AW'($urandom % 8), DW'($urandom), DW'($urandom),
                   LANES'($urandom), LANES'($urandom));
            else if (op == 1)
                rd(AW'($urandom % 8));
            else
                nop();
        end
        nop(); nop(); nop();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule